// File: doc/BRIEF.md
# Hybrid Fast/Dense Bank Placement Controller

This block decides where the blocks of one cache set live when the set is spread over a row of bank clusters. Each cluster holds one fast bank and one dense bank, and each bank gives the set `WAYS` ways. The fast bank and the dense bank of a cluster form a pair, and the dense bank serves as overflow for its fast partner. A block fetched from off-chip memory always lands in a dense bank. Only a block that is used again moves up into a fast bank. A block pushed out of a fast bank drops back into a dense bank, so blocks leave the cache only from dense banks.

The block accepts one event per cycle. An event is either a fill, which carries the incoming block's tag, or a lookup hit, which names the bank, the way and the requesting core. Core `c` sits next to cluster `c`, and the clusters form a line. One cycle after each event the block reports the result on three independent command groups. The move group carries the source and destination bank and way and the moving tag. The demote group reports a block pushed out of a fast bank. The evict group reports a block leaving the cache. The block keeps the valid bits, tags and recency order of every bank set internally. Data storage, the network and bank timing are left to the surrounding logic.

Top module: `hnuca_placer`

## Requirements
- R1: After reset every way of every bank is empty, and all three command groups stay idle until an event arrives.
- R2: A fill goes to the dense bank of cluster `tag mod NUM_CL`. It takes the lowest-numbered empty way, or the least recently used way if the bank is full. A fill never produces a move or a demotion.
- R3: A fill into a full dense bank reports the LRU block it replaces on the evict group with bank, way and tag. Bank codes are `{dense_bit, cluster}` with dense_bit=1 for dense banks.
- R4: A hit in a dense bank moves the block to the fast bank of the same cluster, into that bank's victim way. When nothing is displaced, the dense way becomes empty.
- R5: If that fast way was occupied, its block is demoted into the dense way just vacated, in the same cluster. This produces no eviction.
- R6: A hit in a fast bank whose cluster differs from the requesting core's moves the block exactly one cluster toward that core, into the victim way of that fast bank. The source way becomes empty.
- R7: A hit in a fast bank at the requesting core's own cluster moves nothing. It only makes that way the most recently used.
- R8: When a one-step move lands on an occupied fast way, the displaced block is demoted into the victim way of the destination's paired dense bank. If that dense way was occupied, its block is reported on the evict group.
- R9: Every fill, hit and placement makes the touched way the most recently used of its bank. Victims are the lowest empty way, otherwise the least recently used one.
- R10: A hit that names an empty way is ignored: it produces no command and changes no state.
- R11: Commands appear exactly one cycle after their event. Each event produces at most one move, one demotion and one eviction, and a cycle without an event produces none.
- R12: No move ever goes from a dense bank to a dense bank. Move destinations are always fast banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Event present this cycle |
| in_fill | input | 1 | 1 = fill from off-chip, 0 = lookup hit |
| in_bank | input | CL_W+1 | Hit bank code {dense_bit, cluster} |
| in_way | input | WW | Hit way |
| in_core | input | CL_W | Requesting core (nearest cluster) |
| in_tag | input | TAG_W | Fill tag; low CL_W bits choose the dense bank |
| mv_valid | output | 1 | Move command |
| mv_src_bank | output | CL_W+1 | Move source bank code |
| mv_src_way | output | WW | Move source way |
| mv_dst_bank | output | CL_W+1 | Move destination bank code |
| mv_dst_way | output | WW | Move destination way |
| mv_tag | output | TAG_W | Tag of the moving block |
| dm_valid | output | 1 | Demotion command |
| dm_src_bank | output | CL_W+1 | Fast bank the block leaves |
| dm_src_way | output | WW | Way it leaves |
| dm_dst_bank | output | CL_W+1 | Dense bank receiving it |
| dm_dst_way | output | WW | Way receiving it |
| dm_tag | output | TAG_W | Tag of the demoted block |
| evict_valid | output | 1 | Eviction notice |
| evict_bank | output | CL_W+1 | Dense bank losing the block |
| evict_way | output | WW | Way losing the block |
| evict_tag | output | TAG_W | Tag of the evicted block |

## Verification
A directed sequence first fills one dense bank past capacity. It then promotes out of that bank, steps a block between fast banks, hits at the requester's own cluster, and hits an emptied way. This separates a plain fill from a replacing fill, a promotion with a displaced block from one without, and a real step from a stay in place. A long run of mixed random fills, hits on empty ways and idle cycles follows. Because it re-uses tags, it drives banks into full sets where only the recency order decides the victim. The timestamp-based reference in the bench then tells a correct LRU apart from any fixed or rotating choice of victim.

// File: rtl/hnuca_pkg.sv
package hnuca_pkg;

  // classification of one incoming event
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_FILL,
    ACT_LIFT,
    ACT_STEP,
    ACT_STAY
  } act_e;

endpackage

// File: rtl/hnuca_bank_set.sv
module hnuca_bank_set #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int WW    = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WW-1:0]               wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        clr_en,
  input  logic [WW-1:0]               clr_way,
  input  logic                        touch_en,
  input  logic [WW-1:0]               touch_way,
  output logic [WAYS-1:0]             valid,
  output logic [WAYS-1:0][TAG_W-1:0]  tags,
  output logic [WW-1:0]               victim
);

  logic [WAYS-1:0]            valid_q, valid_d;
  logic [WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [WAYS-1:0][WW-1:0]    age_q, age_d;
  logic                       use_en, upd_en, found;
  logic [WW-1:0]              use_way;

  assign use_en  = wr_en | touch_en;
  assign use_way = wr_en ? wr_way : touch_way;
  assign upd_en  = wr_en | clr_en | touch_en;

  // next state: contents and recency ranks (0 = most recent)
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    age_d   = age_q;
    if (wr_en) begin
      valid_d[wr_way] = 1'b1;
      tag_d[wr_way]   = wr_tag;
    end
    if (clr_en) valid_d[clr_way] = 1'b0;
    if (use_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WW'(i) == use_way)               age_d[i] = '0;
        else if (age_q[i] < age_q[use_way])  age_d[i] = age_q[i] + WW'(1);
      end
    end
  end

  // victim: lowest empty way, otherwise the oldest rank
  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_q[i] && !found) begin
        victim = WW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == WW'(WAYS - 1)) victim = WW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      for (int i = 0; i < WAYS; i++) age_q[i] <= WW'(i);
    end else if (upd_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      age_q   <= age_d;
    end
  end

  assign valid = valid_q;
  assign tags  = tag_q;

  // a written way holds the written block on the next cycle
  assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_way)] && (tag_q[$past(wr_way)] == $past(wr_tag)));

  // any use makes that way the most recent
  assert_touch_mru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    use_en |=> (age_q[$past(use_way)] == '0));

  // a cleared way is empty afterwards
  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !valid_q[$past(clr_way)]);

endmodule

// File: rtl/hnuca_decide.sv
module hnuca_decide
  import hnuca_pkg::*;
#(
  parameter int NUM_CL = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 8,
  parameter int CL_W   = 2,
  parameter int WW     = 1,
  parameter int NB     = 8
) (
  input  logic                        ev_valid,
  input  logic                        ev_fill,
  input  logic [CL_W:0]               ev_bank,
  input  logic [WW-1:0]               ev_way,
  input  logic [CL_W-1:0]             ev_core,
  input  logic [TAG_W-1:0]            ev_tag,
  input  logic [WAYS-1:0]             b_valid [NB],
  input  logic [WAYS-1:0][TAG_W-1:0]  b_tag   [NB],
  input  logic [WW-1:0]               b_vict  [NB],
  output logic                        wr_en     [NB],
  output logic [WW-1:0]               wr_way    [NB],
  output logic [TAG_W-1:0]            wr_tag    [NB],
  output logic                        clr_en    [NB],
  output logic [WW-1:0]               clr_way   [NB],
  output logic                        touch_en  [NB],
  output logic [WW-1:0]               touch_way [NB],
  output logic                        mv_v,
  output logic [CL_W:0]               mv_sb,
  output logic [WW-1:0]               mv_sw,
  output logic [CL_W:0]               mv_db,
  output logic [WW-1:0]               mv_dw,
  output logic [TAG_W-1:0]            mv_t,
  output logic                        dm_v,
  output logic [CL_W:0]               dm_sb,
  output logic [WW-1:0]               dm_sw,
  output logic [CL_W:0]               dm_db,
  output logic [WW-1:0]               dm_dw,
  output logic [TAG_W-1:0]            dm_t,
  output logic                        ex_v,
  output logic [CL_W:0]               ex_b,
  output logic [WW-1:0]               ex_w,
  output logic [TAG_W-1:0]            ex_t
);

  act_e            act;
  logic [CL_W-1:0] cl, step_cl;
  logic [CL_W:0]   fill_b, fast_b, dense_b;
  logic [WW-1:0]   fv, dv;
  logic [TAG_W-1:0] mt, dt;

  assign cl      = ev_bank[CL_W-1:0];
  assign step_cl = (cl < ev_core) ? cl + CL_W'(1) : cl - CL_W'(1);
  assign fill_b  = {1'b1, ev_tag[CL_W-1:0]};

  // classify the event
  always_comb begin
    act = ACT_IDLE;
    if (ev_valid) begin
      if (ev_fill)                               act = ACT_FILL;
      else if (!b_valid[ev_bank][ev_way])        act = ACT_IDLE;
      else if (ev_bank[CL_W])                    act = ACT_LIFT;
      else if (cl == ev_core)                    act = ACT_STAY;
      else                                       act = ACT_STEP;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      wr_en[b] = 1'b0; wr_way[b] = '0; wr_tag[b] = '0;
      clr_en[b] = 1'b0; clr_way[b] = '0;
      touch_en[b] = 1'b0; touch_way[b] = '0;
    end
    mv_v = 1'b0; mv_sb = '0; mv_sw = '0; mv_db = '0; mv_dw = '0; mv_t = '0;
    dm_v = 1'b0; dm_sb = '0; dm_sw = '0; dm_db = '0; dm_dw = '0; dm_t = '0;
    ex_v = 1'b0; ex_b = '0; ex_w = '0; ex_t = '0;
    fast_b  = '0;
    dense_b = '0;
    fv = '0; dv = '0; mt = '0; dt = '0;

    case (act)
      ACT_FILL: begin
        dv = b_vict[fill_b];
        if (b_valid[fill_b][dv]) begin
          ex_v = 1'b1; ex_b = fill_b; ex_w = dv; ex_t = b_tag[fill_b][dv];
        end
        wr_en[fill_b] = 1'b1; wr_way[fill_b] = dv; wr_tag[fill_b] = ev_tag;
      end

      ACT_LIFT: begin
        fast_b = {1'b0, cl};
        fv     = b_vict[fast_b];
        mt     = b_tag[ev_bank][ev_way];
        mv_v = 1'b1; mv_sb = ev_bank; mv_sw = ev_way;
        mv_db = fast_b; mv_dw = fv; mv_t = mt;
        wr_en[fast_b] = 1'b1; wr_way[fast_b] = fv; wr_tag[fast_b] = mt;
        if (b_valid[fast_b][fv]) begin
          dt   = b_tag[fast_b][fv];
          dm_v = 1'b1; dm_sb = fast_b; dm_sw = fv;
          dm_db = ev_bank; dm_dw = ev_way; dm_t = dt;
          wr_en[ev_bank] = 1'b1; wr_way[ev_bank] = ev_way; wr_tag[ev_bank] = dt;
        end else begin
          clr_en[ev_bank] = 1'b1; clr_way[ev_bank] = ev_way;
        end
      end

      ACT_STEP: begin
        fast_b  = {1'b0, step_cl};
        dense_b = {1'b1, step_cl};
        fv      = b_vict[fast_b];
        mt      = b_tag[ev_bank][ev_way];
        mv_v = 1'b1; mv_sb = ev_bank; mv_sw = ev_way;
        mv_db = fast_b; mv_dw = fv; mv_t = mt;
        clr_en[ev_bank] = 1'b1; clr_way[ev_bank] = ev_way;
        wr_en[fast_b] = 1'b1; wr_way[fast_b] = fv; wr_tag[fast_b] = mt;
        if (b_valid[fast_b][fv]) begin
          dt   = b_tag[fast_b][fv];
          dv   = b_vict[dense_b];
          dm_v = 1'b1; dm_sb = fast_b; dm_sw = fv;
          dm_db = dense_b; dm_dw = dv; dm_t = dt;
          if (b_valid[dense_b][dv]) begin
            ex_v = 1'b1; ex_b = dense_b; ex_w = dv; ex_t = b_tag[dense_b][dv];
          end
          wr_en[dense_b] = 1'b1; wr_way[dense_b] = dv; wr_tag[dense_b] = dt;
        end
      end

      ACT_STAY: begin
        touch_en[ev_bank] = 1'b1; touch_way[ev_bank] = ev_way;
      end

      default: ;
    endcase
  end

  // a demotion only ever accompanies a move into an occupied fast way
  always_comb begin
    if (dm_v) assert_demote_needs_move_R5: assert (mv_v && !mv_db[CL_W]);
  end

endmodule

// File: rtl/hnuca_placer.sv
module hnuca_placer #(
  parameter int NUM_CL = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 8,
  localparam int CL_W  = $clog2(NUM_CL),
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_fill,
  input  logic [CL_W:0]     in_bank,
  input  logic [WW-1:0]     in_way,
  input  logic [CL_W-1:0]   in_core,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              mv_valid,
  output logic [CL_W:0]     mv_src_bank,
  output logic [WW-1:0]     mv_src_way,
  output logic [CL_W:0]     mv_dst_bank,
  output logic [WW-1:0]     mv_dst_way,
  output logic [TAG_W-1:0]  mv_tag,
  output logic              dm_valid,
  output logic [CL_W:0]     dm_src_bank,
  output logic [WW-1:0]     dm_src_way,
  output logic [CL_W:0]     dm_dst_bank,
  output logic [WW-1:0]     dm_dst_way,
  output logic [TAG_W-1:0]  dm_tag,
  output logic              evict_valid,
  output logic [CL_W:0]     evict_bank,
  output logic [WW-1:0]     evict_way,
  output logic [TAG_W-1:0]  evict_tag
);

  localparam int NB = 2 * NUM_CL;

  logic [WAYS-1:0]            b_valid   [NB];
  logic [WAYS-1:0][TAG_W-1:0] b_tag     [NB];
  logic [WW-1:0]              b_vict    [NB];
  logic                       wr_en     [NB];
  logic [WW-1:0]              wr_way    [NB];
  logic [TAG_W-1:0]           wr_tag    [NB];
  logic                       clr_en    [NB];
  logic [WW-1:0]              clr_way   [NB];
  logic                       touch_en  [NB];
  logic [WW-1:0]              touch_way [NB];

  logic                nx_mv_v, nx_dm_v, nx_ex_v;
  logic [CL_W:0]       nx_mv_sb, nx_mv_db, nx_dm_sb, nx_dm_db, nx_ex_b;
  logic [WW-1:0]       nx_mv_sw, nx_mv_dw, nx_dm_sw, nx_dm_dw, nx_ex_w;
  logic [TAG_W-1:0]    nx_mv_t, nx_dm_t, nx_ex_t;

  // bank index equals bank code {dense_bit, cluster}
  for (genvar g = 0; g < NB; g++) begin : g_bank
    hnuca_bank_set #(.WAYS(WAYS), .TAG_W(TAG_W), .WW(WW)) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en[g]),
      .wr_way    (wr_way[g]),
      .wr_tag    (wr_tag[g]),
      .clr_en    (clr_en[g]),
      .clr_way   (clr_way[g]),
      .touch_en  (touch_en[g]),
      .touch_way (touch_way[g]),
      .valid     (b_valid[g]),
      .tags      (b_tag[g]),
      .victim    (b_vict[g])
    );
  end

  hnuca_decide #(
    .NUM_CL(NUM_CL), .WAYS(WAYS), .TAG_W(TAG_W), .CL_W(CL_W), .WW(WW), .NB(NB)
  ) u_decide (
    .ev_valid (in_valid), .ev_fill (in_fill), .ev_bank (in_bank),
    .ev_way   (in_way),   .ev_core (in_core), .ev_tag  (in_tag),
    .b_valid  (b_valid),  .b_tag   (b_tag),   .b_vict  (b_vict),
    .wr_en    (wr_en),    .wr_way  (wr_way),  .wr_tag  (wr_tag),
    .clr_en   (clr_en),   .clr_way (clr_way),
    .touch_en (touch_en), .touch_way (touch_way),
    .mv_v (nx_mv_v), .mv_sb (nx_mv_sb), .mv_sw (nx_mv_sw),
    .mv_db (nx_mv_db), .mv_dw (nx_mv_dw), .mv_t (nx_mv_t),
    .dm_v (nx_dm_v), .dm_sb (nx_dm_sb), .dm_sw (nx_dm_sw),
    .dm_db (nx_dm_db), .dm_dw (nx_dm_dw), .dm_t (nx_dm_t),
    .ex_v (nx_ex_v), .ex_b (nx_ex_b), .ex_w (nx_ex_w), .ex_t (nx_ex_t)
  );

  // command registers: one-cycle event-to-command latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_valid <= 1'b0; mv_src_bank <= '0; mv_src_way <= '0;
      mv_dst_bank <= '0; mv_dst_way <= '0; mv_tag <= '0;
      dm_valid <= 1'b0; dm_src_bank <= '0; dm_src_way <= '0;
      dm_dst_bank <= '0; dm_dst_way <= '0; dm_tag <= '0;
      evict_valid <= 1'b0; evict_bank <= '0; evict_way <= '0; evict_tag <= '0;
    end else begin
      mv_valid <= nx_mv_v; mv_src_bank <= nx_mv_sb; mv_src_way <= nx_mv_sw;
      mv_dst_bank <= nx_mv_db; mv_dst_way <= nx_mv_dw; mv_tag <= nx_mv_t;
      dm_valid <= nx_dm_v; dm_src_bank <= nx_dm_sb; dm_src_way <= nx_dm_sw;
      dm_dst_bank <= nx_dm_db; dm_dst_way <= nx_dm_dw; dm_tag <= nx_dm_t;
      evict_valid <= nx_ex_v; evict_bank <= nx_ex_b; evict_way <= nx_ex_w;
      evict_tag <= nx_ex_t;
    end
  end

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !mv_valid && !dm_valid && !evict_valid);

  assert_fill_no_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fill) |=> !mv_valid && !dm_valid);

  assert_evict_dense_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> evict_bank[CL_W]);

  assert_no_dense_hop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !mv_dst_bank[CL_W]);

  assert_lift_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_src_bank[CL_W]) |-> (mv_dst_bank[CL_W-1:0] == mv_src_bank[CL_W-1:0]));

  assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_src_bank[CL_W]) |->
      ((mv_dst_bank[CL_W-1:0] == mv_src_bank[CL_W-1:0] + CL_W'(1)) ||
       (mv_dst_bank[CL_W-1:0] == mv_src_bank[CL_W-1:0] - CL_W'(1))));

  assert_demote_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid |-> dm_dst_bank[CL_W] && (dm_src_bank == mv_dst_bank) &&
                 (dm_src_way == mv_dst_way) &&
                 (dm_dst_bank[CL_W-1:0] == dm_src_bank[CL_W-1:0]));

endmodule

// File: tb/hnuca_placer_tb.sv
`timescale 1ns/1ps
module hnuca_placer_tb;

  localparam int NUM_CL = 4;
  localparam int WAYS   = 2;
  localparam int TAG_W  = 8;
  localparam int CL_W   = 2;
  localparam int WW     = 1;
  localparam int NB     = 2 * NUM_CL;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_fill;
  logic [CL_W:0] in_bank;
  logic [WW-1:0] in_way;
  logic [CL_W-1:0] in_core;
  logic [TAG_W-1:0] in_tag;
  logic mv_valid, dm_valid, evict_valid;
  logic [CL_W:0] mv_src_bank, mv_dst_bank, dm_src_bank, dm_dst_bank, evict_bank;
  logic [WW-1:0] mv_src_way, mv_dst_way, dm_src_way, dm_dst_way, evict_way;
  logic [TAG_W-1:0] mv_tag, dm_tag, evict_tag;

  hnuca_placer #(.NUM_CL(NUM_CL), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fill(in_fill),
    .in_bank(in_bank), .in_way(in_way), .in_core(in_core), .in_tag(in_tag),
    .mv_valid(mv_valid), .mv_src_bank(mv_src_bank), .mv_src_way(mv_src_way),
    .mv_dst_bank(mv_dst_bank), .mv_dst_way(mv_dst_way), .mv_tag(mv_tag),
    .dm_valid(dm_valid), .dm_src_bank(dm_src_bank), .dm_src_way(dm_src_way),
    .dm_dst_bank(dm_dst_bank), .dm_dst_way(dm_dst_way), .dm_tag(dm_tag),
    .evict_valid(evict_valid), .evict_bank(evict_bank), .evict_way(evict_way),
    .evict_tag(evict_tag)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state: validity, tag, last-use timestamp
  int mvalid [NB][WAYS];
  int mtag   [NB][WAYS];
  int mstamp [NB][WAYS];
  int now;

  // expected command fields
  int e_mv, e_msb, e_msw, e_mdb, e_mdw, e_mt;
  int e_dm, e_dsb, e_dsw, e_ddb, e_ddw, e_dt;
  int e_ev, e_eb, e_ew, e_et;
  string e_req;

  function automatic int vict(int b);
    int best;
    for (int w = 0; w < WAYS; w++) if (mvalid[b][w] == 0) return w;
    best = 0;
    for (int w = 1; w < WAYS; w++) if (mstamp[b][w] < mstamp[b][best]) best = w;
    return best;
  endfunction

  task automatic clear_exp();
    e_mv = 0; e_msb = 0; e_msw = 0; e_mdb = 0; e_mdw = 0; e_mt = 0;
    e_dm = 0; e_dsb = 0; e_dsw = 0; e_ddb = 0; e_ddw = 0; e_dt = 0;
    e_ev = 0; e_eb = 0; e_ew = 0; e_et = 0;
  endtask

  task automatic put(int b, int w, int t);
    mvalid[b][w] = 1; mtag[b][w] = t; mstamp[b][w] = now;
  endtask

  task automatic model_ev(int fill, int bank, int way, int core, int tag);
    int cl, t, f, fv, j, dd, dv, dt;
    clear_exp();
    now++;
    cl = bank % NUM_CL;
    if (fill != 0) begin
      dd = NUM_CL + (tag % NUM_CL);
      dv = vict(dd);
      if (mvalid[dd][dv] != 0) begin
        e_ev = 1; e_eb = dd; e_ew = dv; e_et = mtag[dd][dv];
        e_req = "R3 R9";
      end else e_req = "R2";
      put(dd, dv, tag);
    end else if (mvalid[bank][way] == 0) begin
      e_req = "R10";
    end else if (bank >= NUM_CL) begin
      t = mtag[bank][way];
      f = cl; fv = vict(f);
      e_mv = 1; e_msb = bank; e_msw = way; e_mdb = f; e_mdw = fv; e_mt = t;
      if (mvalid[f][fv] != 0) begin
        e_dm = 1; e_dsb = f; e_dsw = fv; e_ddb = bank; e_ddw = way; e_dt = mtag[f][fv];
        put(bank, way, mtag[f][fv]);
        e_req = "R5 R9 R12";
      end else begin
        mvalid[bank][way] = 0;
        e_req = "R4 R12";
      end
      put(f, fv, t);
    end else if (cl == core) begin
      mstamp[bank][way] = now;
      e_req = "R7";
    end else begin
      t = mtag[bank][way];
      j = (cl < core) ? cl + 1 : cl - 1;
      fv = vict(j);
      e_mv = 1; e_msb = bank; e_msw = way; e_mdb = j; e_mdw = fv; e_mt = t;
      mvalid[bank][way] = 0;
      e_req = "R6";
      if (mvalid[j][fv] != 0) begin
        dt = mtag[j][fv];
        dd = NUM_CL + j; dv = vict(dd);
        e_dm = 1; e_dsb = j; e_dsw = fv; e_ddb = dd; e_ddw = dv; e_dt = dt;
        if (mvalid[dd][dv] != 0) begin
          e_ev = 1; e_eb = dd; e_ew = dv; e_et = mtag[dd][dv];
        end
        put(dd, dv, dt);
        e_req = "R8 R9";
      end
      put(j, fv, t);
    end
  endtask

  task automatic check_out();
    bit bad;
    bad = (int'(mv_valid) != e_mv) || (int'(dm_valid) != e_dm) || (int'(evict_valid) != e_ev);
    if (e_mv != 0)
      bad |= (int'(mv_src_bank) != e_msb) || (int'(mv_src_way) != e_msw) ||
             (int'(mv_dst_bank) != e_mdb) || (int'(mv_dst_way) != e_mdw) || (int'(mv_tag) != e_mt);
    if (e_dm != 0)
      bad |= (int'(dm_src_bank) != e_dsb) || (int'(dm_src_way) != e_dsw) ||
             (int'(dm_dst_bank) != e_ddb) || (int'(dm_dst_way) != e_ddw) || (int'(dm_tag) != e_dt);
    if (e_ev != 0)
      bad |= (int'(evict_bank) != e_eb) || (int'(evict_way) != e_ew) || (int'(evict_tag) != e_et);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got mv=%0d %0d.%0d->%0d.%0d t=%0h dm=%0d %0d.%0d->%0d.%0d t=%0h ev=%0d %0d.%0d t=%0h | exp mv=%0d %0d.%0d->%0d.%0d t=%0h dm=%0d %0d.%0d->%0d.%0d t=%0h ev=%0d %0d.%0d t=%0h",
        e_req, mv_valid, mv_src_bank, mv_src_way, mv_dst_bank, mv_dst_way, mv_tag,
        dm_valid, dm_src_bank, dm_src_way, dm_dst_bank, dm_dst_way, dm_tag,
        evict_valid, evict_bank, evict_way, evict_tag,
        e_mv, e_msb, e_msw, e_mdb, e_mdw, e_mt, e_dm, e_dsb, e_dsw, e_ddb, e_ddw, e_dt,
        e_ev, e_eb, e_ew, e_et);
    end
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic do_ev(int fill, int bank, int way, int core, int tag);
    in_valid = 1'b1; in_fill = fill[0];
    in_bank = (CL_W+1)'(bank); in_way = WW'(way);
    in_core = CL_W'(core); in_tag = TAG_W'(tag);
    model_ev(fill, bank, way, core, tag);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle();
    in_valid = 1'b0;
    clear_exp();
    e_req = "R11";
    @(negedge clk);
    check_out();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got running, exp finished");
    summary();
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WAYS; w++) begin
        mvalid[b][w] = 0; mtag[b][w] = 0; mstamp[b][w] = 0;
      end
    now = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_fill = 1'b0; in_bank = '0;
    in_way = '0; in_core = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    clear_exp(); e_req = "R1";
    check_out();                       // R1: idle outputs in reset
    rst_n = 1'b1;
    idle();                            // R1 R11: nothing after release
    do_ev(0, 5, 0, 1, 0);              // R10: hit on an empty dense way
    // R2 and R3: overfill dense bank of cluster 1
    do_ev(1, 0, 0, 0, 'h11);
    do_ev(1, 0, 0, 0, 'h21);
    do_ev(1, 0, 0, 0, 'h31);           // R3: evicts 0x11 (LRU)
    do_ev(0, 5, 1, 3, 0);              // R4: 0x21 lifted to fast1
    do_ev(0, 1, 0, 3, 0);              // R6: fast1 -> fast2
    do_ev(0, 2, 0, 2, 0);              // R7: at own cluster
    do_ev(0, 1, 0, 3, 0);              // R10: emptied way
    idle();                            // R11
    do_ev(1, 0, 0, 0, 'h42);
    do_ev(1, 0, 0, 0, 'h52);
    do_ev(0, 6, 0, 2, 0);              // R4: lift into empty fast2 way
    do_ev(0, 6, 1, 2, 0);              // R5: lift into full fast2
    do_ev(1, 0, 0, 0, 'h61);
    do_ev(0, 5, 1, 1, 0);              // R4
    do_ev(0, 1, 0, 3, 0);              // R8: step into full fast2
    // mixed random traffic
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) idle();
      else if (r < 4) do_ev(1, 0, 0, 0, $urandom_range(0, 255));
      else do_ev(0, $urandom_range(0, NB-1), $urandom_range(0, WAYS-1),
                 $urandom_range(0, NUM_CL-1), 0);
    end
    idle();
    summary();
    $finish;
  end

endmodule